// File: doc/BRIEF.md
# Current Alert Monitor

The block watches a stream of current-channel ADC samples and decides when to raise an alert. Each sample word arrives with a valid strobe. Only its most significant byte is compared with an 8-bit threshold. Two trigger modes can be armed at the same time. In one, a single exceeding sample is enough. In the other, a run of consecutive exceeding samples is required (four by default). When either armed mode fires, a conversion-alert status bit is set and stays latched.

A second latched status bit records an overcurrent condition. It is fed by a timer-expired indication from the hot-swap timer. A software turn-off request can also drive the alert output, but only when its enable bit permits it. A clear pulse empties both status bits. If the cause is still present and still enabled, the bit sets again on the cycle after the clear. The enable, threshold and control values come from a register file outside the block. The alert output is the OR of all three alert sources.

Top module: `current_alert_monitor`

## Requirements
- R1: A valid sample exceeds the threshold only when its upper eight bits `smp_data[11:4]` are strictly greater than `alert_th`. The lower four bits never affect the result.
- R2: With `alert_en[0]` set, the first clock edge that takes in an exceeding valid sample also sets `conv_status`.
- R3: With `alert_en[1]` set, `conv_status` is set on the edge that takes in the fourth exceeding valid sample of an unbroken run. A valid sample that does not exceed the threshold restarts the run at zero.
- R4: The run count saturates at four. Once a run has reached four, every further exceeding valid sample satisfies the run condition again, even after a clear.
- R5: With `alert_en[2]` set, a high `oc_trip` at a clock edge sets `oc_status`. Once set, `oc_status` stays set until it is cleared or reset. With `alert_en[2]` low, `oc_trip` has no effect.
- R6: A `clr` pulse at an edge zeroes both `oc_status` and `conv_status`, and it wins over any set at the same edge. A cause that persists sets the bit again at the following edge.
- R7: While `alert_en[3]` and `ctrl[0]` are both high, `alert` is high in the same cycle. `ctrl[0]` has no effect while `alert_en[3]` is low.
- R8: `alert` is high exactly when `oc_status` is high, `conv_status` is high, or the software turn-off condition of R7 holds.
- R9: A low `rst_n` at a clock edge zeroes both status bits and the run count.
- R10: A cycle with `smp_valid` low neither sets `conv_status` nor advances or breaks a run, whatever `smp_data` holds.
- R11: With `alert_th` at 0xFF (full scale), no sample can trigger a conversion alert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 12 | Current-channel ADC sample |
| oc_trip | input | 1 | Overcurrent timer has reached its trip level |
| alert_en | input | 8 | Alert enables: bit0 single-sample, bit1 four-in-a-row, bit2 overcurrent, bit3 software turn-off |
| alert_th | input | 8 | Threshold, compared with the sample's upper byte |
| ctrl | input | 8 | Control value, bit0 requests software turn-off |
| clr | input | 1 | One-cycle pulse that clears both status bits |
| oc_status | output | 1 | Latched overcurrent status |
| conv_status | output | 1 | Latched conversion-alert status |
| alert | output | 1 | Combined alert output |

## Verification
The bench builds the block with its defaults: 12-bit samples, an 8-bit threshold and a run length of four. At these sizes every upper-byte value can be swept against several thresholds, including the equal and one-above boundaries and 0xFF. Every 8-sample exceed/miss pattern is applied in four-in-a-row mode, with an invalid cycle placed inside each run. All sixteen low enable combinations are crossed with overcurrent, clear and software turn-off sequences.

// File: rtl/cam_pkg.sv
// Package: bit positions and the status type shared by the alert monitor.
// Assumes the enable and control registers are at least 4 and 1 bits wide.
package cam_pkg;
    localparam int EN_SINGLE  = 0;  // one exceeding sample arms conversion alert
    localparam int EN_RUN     = 1;  // run of exceeding samples arms conversion alert
    localparam int EN_OC      = 2;  // overcurrent capture enable
    localparam int EN_SWOFF   = 3;  // software turn-off may drive the alert
    localparam int CTRL_SWOFF = 0;  // software turn-off request bit

    localparam int N_STAT = 2;
    localparam int ST_OC   = 0;
    localparam int ST_CONV = 1;

    typedef logic [N_STAT-1:0] stat_vec_t;
endpackage

// File: rtl/cam_compare.sv
// Module: cam_compare
// Compares the upper TH_W bits of a sample with a threshold (strictly greater).
// Assumes SMP_W >= TH_W. Output is combinational and gated by the valid strobe.
module cam_compare #(
    parameter int SMP_W = 12,
    parameter int TH_W  = 8
) (
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [TH_W-1:0]  thresh,
    output logic             hit
);
    localparam int TOP_LSB = SMP_W - TH_W;

    logic [TH_W-1:0] top_bits;

    // Purpose: pick the sample's upper bits and test them against the threshold.
    always_comb begin
        top_bits = smp_data[TOP_LSB +: TH_W];
        hit      = smp_valid && (top_bits > thresh);
    end
endmodule

// File: rtl/cam_run_counter.sv
// Module: cam_run_counter
// Counts consecutive exceeding valid samples, saturating at RUN_LEN.
// Assumes hit is already qualified by smp_valid; invalid cycles hold the count.
module cam_run_counter #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic hit,
    output logic run_met
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Purpose: next count: hold when idle, restart on a miss, saturate on a hit.
    always_comb begin
        cnt_d = cnt_q;
        if (smp_valid) begin
            if (!hit)
                cnt_d = '0;
            else if (cnt_q != CNT_MAX)
                cnt_d = cnt_q + CNT_W'(1);
        end
        run_met = hit && (cnt_d == CNT_MAX);
    end

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cam_status.sv
// Module: cam_status
// A bank of sticky status bits. Clear has priority over set in the same cycle.
// Assumes set and clear are single-cycle qualified requests.
module cam_status
    import cam_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  stat_vec_t set_req,
    input  logic      clr,
    output stat_vec_t stat_q
);
    for (genvar i = 0; i < N_STAT; i++) begin : g_bit
        // Purpose: one sticky bit: reset, then clear, then set-or-hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (clr)
                stat_q[i] <= 1'b0;
            else if (set_req[i])
                stat_q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/current_alert_monitor.sv
// Module: current_alert_monitor
// Top level. Tests current samples against a threshold in single-sample and
// run modes, latches overcurrent and conversion alerts, and drives the alert.
// Assumes the register values are stable in a register file outside the block.
module current_alert_monitor
    import cam_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int TH_W    = 8,
    parameter int REG_W   = 8,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             oc_trip,
    input  logic [REG_W-1:0] alert_en,
    input  logic [TH_W-1:0]  alert_th,
    input  logic [REG_W-1:0] ctrl,
    input  logic             clr,
    output logic             oc_status,
    output logic             conv_status,
    output logic             alert
);
    logic      hit;
    logic      run_met;
    logic      swoff_on;
    stat_vec_t set_req;
    stat_vec_t stat_q;

    cam_compare #(.SMP_W(SMP_W), .TH_W(TH_W)) u_cmp (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (alert_th),
        .hit       (hit)
    );

    cam_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hit       (hit),
        .run_met   (run_met)
    );

    // Purpose: form the set requests from the armed trigger modes.
    always_comb begin
        set_req          = '0;
        set_req[ST_OC]   = oc_trip && alert_en[EN_OC];
        set_req[ST_CONV] = (hit && alert_en[EN_SINGLE]) ||
                           (run_met && alert_en[EN_RUN]);
    end

    cam_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr     (clr),
        .stat_q  (stat_q)
    );

    // Purpose: combine the latched bits and the gated software turn-off.
    always_comb begin
        swoff_on    = alert_en[EN_SWOFF] && ctrl[CTRL_SWOFF];
        oc_status   = stat_q[ST_OC];
        conv_status = stat_q[ST_CONV];
        alert       = oc_status || conv_status || swoff_on;
    end
endmodule

// File: rtl/cam_checker.sv
// Module: cam_checker
// Temporal properties of the alert monitor, observed at its ports.
module cam_checker #(
    parameter int SMP_W = 12,
    parameter int TH_W  = 8,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic             oc_trip,
    input logic [REG_W-1:0] alert_en,
    input logic [TH_W-1:0]  alert_th,
    input logic [REG_W-1:0] ctrl,
    input logic             clr,
    input logic             oc_status,
    input logic             conv_status,
    input logic             alert
);
    localparam int TOP_LSB = SMP_W - TH_W;

    // R2: an armed single-sample hit sets the conversion status next cycle
    a_r2_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_data[TOP_LSB +: TH_W] > alert_th && alert_en[0] && !clr)
        |=> conv_status);

    // R5: an armed overcurrent trip sets the overcurrent status
    a_r5_oc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_trip && alert_en[2] && !clr) |=> oc_status);

    // R5: the overcurrent status is sticky until cleared
    a_r5_oc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_status && !clr) |=> oc_status);

    // R6: clear wins over every set request
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!oc_status && !conv_status));

    // R10: the conversion status rises only after a valid sample
    a_r10_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_status) |-> $past(smp_valid));

    // R11: a full-scale threshold never triggers a conversion alert
    a_r11_fullscale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_th == '1 && !conv_status) |=> !conv_status);

    // R8: a latched status always shows on the alert output
    a_r8_status_alerts: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_status || conv_status) |-> alert);

    // R7: without its enable, the turn-off request cannot raise the alert alone
    a_r7_swoff_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_en[3] && !oc_status && !conv_status) |-> !alert);
endmodule

bind current_alert_monitor cam_checker #(
    .SMP_W (SMP_W),
    .TH_W  (TH_W),
    .REG_W (REG_W)
) u_cam_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .oc_trip     (oc_trip),
    .alert_en    (alert_en),
    .alert_th    (alert_th),
    .ctrl        (ctrl),
    .clr         (clr),
    .oc_status   (oc_status),
    .conv_status (conv_status),
    .alert       (alert)
);

// File: tb/tb_current_alert_monitor.sv
// Bench: sweeps of the default configuration against a reference model
// computed from the requirements.
module tb_current_alert_monitor;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        oc_trip = 1'b0;
    logic [7:0]  alert_en = '0;
    logic [7:0]  alert_th = 8'hFF;
    logic [7:0]  ctrl = '0;
    logic        clr = 1'b0;
    logic        oc_status, conv_status, alert;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state
    bit m_oc = 0, m_conv = 0;
    int m_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    current_alert_monitor dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .oc_trip(oc_trip), .alert_en(alert_en), .alert_th(alert_th),
        .ctrl(ctrl), .clr(clr), .oc_status(oc_status),
        .conv_status(conv_status), .alert(alert)
    );

    task automatic chk(input string tag, input string what, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %0b exp %0b (th=%h data=%h en=%h ctrl=%h)",
                     tag, what, act, exp, alert_th, smp_data, alert_en, ctrl);
        end
    endtask

    // Caller drives inputs at a negedge; one clock is applied and outputs checked.
    task automatic step(input string tag);
        bit exceed, conv_set, oc_set;
        int cnt_n;
        exceed = smp_valid && (smp_data[11:4] > alert_th);
        cnt_n = !smp_valid ? m_cnt : (exceed ? ((m_cnt < 4) ? m_cnt + 1 : 4) : 0);
        conv_set = exceed && (alert_en[0] || (alert_en[1] && cnt_n == 4));
        oc_set = oc_trip && alert_en[2];
        @(posedge clk);
        #(CLK_P/4);
        if (!rst_n) begin
            m_oc = 0; m_conv = 0; m_cnt = 0;
        end else begin
            m_cnt = cnt_n;
            if (clr) begin
                m_oc = 0; m_conv = 0;
            end else begin
                m_oc = m_oc | oc_set;
                m_conv = m_conv | conv_set;
            end
        end
        chk(tag, "oc_status", oc_status, m_oc);
        chk(tag, "conv_status", conv_status, m_conv);
        chk(tag, "alert", alert, m_oc | m_conv | (alert_en[3] & ctrl[0]));
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        smp_valid = 0; smp_data = '0; oc_trip = 0; clr = 0; ctrl = '0;
    endtask

    task automatic do_clear();
        idle_inputs();
        clr = 1;
        step("R6");
        clr = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset state
        rst_n = 0;
        step("R9");
        step("R9");
        rst_n = 1;
        step("R9");

        // R1, R2, R11: every upper byte, both low-nibble extremes, several thresholds
        foreach (th_list[k]) begin end
        for (int t = 0; t < 6; t++) begin
            logic [7:0] th;
            case (t)
                0: th = 8'h00;
                1: th = 8'h37;
                2: th = 8'h80;
                3: th = 8'hC5;
                4: th = 8'hFE;
                default: th = 8'hFF;
            endcase
            for (int top = 0; top < 256; top++) begin
                for (int nib = 0; nib < 2; nib++) begin
                    do_clear();
                    alert_en = 8'h01;
                    alert_th = th;
                    smp_valid = 1;
                    smp_data = {top[7:0], (nib == 1) ? 4'hF : 4'h0};
                    step((th == 8'hFF) ? "R11" : ((top == th || top == th + 1) ? "R1" : "R2"));
                    smp_valid = 0;
                    step("R2");
                end
            end
        end

        // R3, R4, R10: all 8-sample exceed/miss patterns in run mode
        alert_th = 8'h40;
        alert_en = 8'h02;
        for (int pat = 0; pat < 256; pat++) begin
            rst_n = 0;
            idle_inputs();
            step("R9");
            rst_n = 1;
            for (int b = 0; b < 8; b++) begin
                smp_valid = 1;
                smp_data = pat[b] ? 12'h41F : 12'h400;
                step("R3");
                if (b == 2) begin
                    // R10: invalid cycle with a non-exceeding word must not break the run
                    smp_valid = 0;
                    smp_data = 12'h000;
                    step("R10");
                    smp_data = 12'hFFF;
                    step("R10");
                end
            end
            // R4: after a clear, a saturated run re-fires on the next exceeding sample
            do_clear();
            smp_valid = 1;
            smp_data = 12'hFF0;
            step("R4");
            smp_valid = 0;
        end

        // R5, R6, R7, R8: every low enable combination with trip, clear, turn-off
        for (int e = 0; e < 16; e++) begin
            do_clear();
            alert_en = 8'(e);
            alert_th = 8'h10;
            oc_trip = 1;
            step("R5");
            oc_trip = 0;
            step("R5");
            step("R5");
            oc_trip = 1; clr = 1;
            step("R6");
            clr = 0;
            step("R6");
            oc_trip = 0;
            smp_valid = 1; smp_data = 12'h200; clr = 1;
            step("R6");
            clr = 0;
            step("R6");
            smp_valid = 0;
            for (int c = 0; c < 4; c++) begin
                ctrl = 8'(c);
                step("R7");
            end
            do_clear();
            for (int c = 0; c < 2; c++) begin
                ctrl = 8'(c) | 8'hFE;
                step("R8");
            end
            ctrl = '0;
        end

        // R9: reset in the middle of latched state
        alert_en = 8'h07;
        oc_trip = 1; smp_valid = 1; smp_data = 12'hFFF; alert_th = 8'h00;
        step("R9");
        oc_trip = 0; smp_valid = 0; rst_n = 0;
        step("R9");
        rst_n = 1;
        step("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    logic [0:0] th_list [1];
endmodule